// File: doc/BRIEF.md
# Flash Page Program and Erase Engine

This block carries out program and erase work on an on-chip byte array that behaves like flash storage. A host streams up to one page of data bytes into a page buffer over a valid/ready byte channel, then issues a start strobe with an operation class and a byte address. A program operation merges the buffered bytes into one page by bitwise AND, so bits can only go from 1 to 0. A sector erase sets one sector to FFh, and a bulk erase sets the whole array to FFh. A status-write class runs a timed cycle only, with no effect on the array.

Each accepted operation holds `busy` high for its own cycle time. The host may poll `busy`. A one-cycle `done` pulse marks completion, so the surrounding logic can drop its write-enable latch. The default array is 2 KB, split into four 512-byte sectors of two 256-byte pages each. Setting `ADDR_W` to 17 and `SECT_W` to 15 gives a 128 KB array of four 32 KB sectors. The cycle times are parameters in clock counts. A read port returns any array byte one cycle after its address is presented. Command decoding and protection checks belong to the surrounding logic.

Back-pressure on the byte channel is simple. `s_ready` is high exactly when the engine is not busy. A byte moves on a rising edge where both `s_valid` and `s_ready` are high. A byte moved in the same cycle as a program start is part of that program. The host must hold `s_valid` and `s_data` until the byte is taken.

Top module: `fpe_engine`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `s_ready` is 1.
- R2: `s_ready` equals the inverse of `busy`, and a byte offered while busy is not stored. Byte k since the last program (k counted from 0) is meant for page column (start column + k) mod 256, wrapping within the same page.
- R3: If more than 256 bytes arrive before a program, only the last 256 take effect. Each column then holds the latest byte meant for it.
- R4: A program (op = 0) writes new = old AND data for each buffered byte. It only touches the page chosen by `addr[ADDR_W-1:8]`, and `addr[7:0]` is the start column.
- R5: A sector erase (op = 1) sets every byte of the sector chosen by `addr[ADDR_W-1:SECT_W]` to FFh and leaves the other sectors unchanged.
- R6: A bulk erase (op = 2) sets every byte of the array to FFh.
- R7: A start accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly max(T_PP,256) cycles for a program, max(T_SE,sector size) for a sector erase, max(T_BE,array size) for a bulk erase, and max(T_W,1) for a status write (op = 3). A status write leaves the array unchanged.
- R8: `done` is high for exactly one cycle, the first cycle after `busy` falls, and at no other time.
- R9: A start strobe while `busy` is high is ignored. It changes neither the busy length nor the array.
- R10: The page buffer is emptied when a program completes. A program with no new bytes leaves the array unchanged.
- R11: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request strobe |
| op | input | 2 | Operation class: 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| addr | input | ADDR_W | Byte address: page and start column, or sector |
| s_valid | input | 1 | Data byte offered |
| s_ready | output | 1 | Engine accepts a data byte |
| s_data | input | 8 | Data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte, one cycle after `rd_addr` |

## Verification
The bound checker watches the timing contract on every cycle. It checks that each busy window has exactly the length set by the class captured at start, that `done` is a single pulse right after `busy` falls, that `s_ready` tracks `busy`, and that the array is never written while idle. The array contents can only be shown by the bench's scenarios, which compare a full read-back against a bench-side model. These scenarios cover column wrap, the last-256 rule, AND merging over existing data, and sector bounds. They also check that ignored starts and ignored bytes leave no trace in the array.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    FPE_PROG = 2'd0,
    FPE_SECT = 2'd1,
    FPE_BULK = 2'd2,
    FPE_STAT = 2'd3
  } fpe_op_e;
endpackage

// File: rtl/fpe_page_buf.sv
module fpe_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [7:0]        din,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic [7:0]        rd_byte,
  output logic [PAGE_W:0]   fill
);
  localparam int PAGE_B = 1 << PAGE_W;

  logic [7:0]        slots [PAGE_B];
  logic [PAGE_W-1:0] wr_ptr;

  // Circular store: slot k mod page holds the latest byte for that slot.
  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (push) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill != (PAGE_W+1)'(PAGE_B)) fill <= fill + 1'b1;
    end
  end

  assign rd_byte = slots[rd_slot];
endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic              set_ff,
  input  logic [ADDR_W-1:0] wa,
  input  logic [7:0]        wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [7:0]        rdata
);
  localparam int ARR_B = 1 << ADDR_W;

  logic [7:0] cells [ARR_B];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= set_ff ? 8'hFF : (cells[wa] & wd);
    rdata <= cells[ra];
  end
endmodule

// File: rtl/fpe_seq.sv
module fpe_seq
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter int T_PP   = 300,
  parameter int T_SE   = 600,
  parameter int T_BE   = 2100,
  parameter int T_W    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fpe_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W:0]   fill,
  output logic              busy,
  output logic              done,
  output logic              arr_we,
  output logic              arr_set,
  output logic [ADDR_W-1:0] arr_wa,
  output logic [PAGE_W-1:0] buf_slot,
  output logic              buf_clr
);
  localparam int PAGE_B = 1 << PAGE_W;
  localparam int SECT_B = 1 << SECT_W;
  localparam int ARR_B  = 1 << ADDR_W;
  localparam int D_PP   = (T_PP > PAGE_B) ? T_PP : PAGE_B;
  localparam int D_SE   = (T_SE > SECT_B) ? T_SE : SECT_B;
  localparam int D_BE   = (T_BE > ARR_B)  ? T_BE : ARR_B;
  localparam int D_W    = (T_W > 1) ? T_W : 1;
  localparam int D_M1   = (D_PP > D_SE) ? D_PP : D_SE;
  localparam int D_M2   = (D_BE > D_W)  ? D_BE : D_W;
  localparam int D_MAX  = (D_M1 > D_M2) ? D_M1 : D_M2;
  localparam int CW     = $clog2(D_MAX + 1);

  function automatic logic [CW-1:0] last_tick(fpe_op_e o);
    case (o)
      FPE_PROG: return CW'(D_PP - 1);
      FPE_SECT: return CW'(D_SE - 1);
      FPE_BULK: return CW'(D_BE - 1);
      default:  return CW'(D_W - 1);
    endcase
  endfunction

  fpe_op_e           op_q;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     remain_q;
  logic [CW-1:0]     idx_q;
  logic [CW-1:0]     len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= FPE_STAT;
      base_q   <= '0;
      remain_q <= '0;
      idx_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          op_q     <= op;
          base_q   <= addr;
          idx_q    <= '0;
          remain_q <= last_tick(op);
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (remain_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain_q <= remain_q - 1'b1;
        end
      end
    end
  end

  // Number of array bytes the current operation walks, one per cycle.
  always_comb begin
    case (op_q)
      FPE_PROG: len = CW'(fill);
      FPE_SECT: len = CW'(SECT_B);
      FPE_BULK: len = CW'(ARR_B);
      default:  len = '0;
    endcase
  end

  always_comb begin
    case (op_q)
      FPE_PROG: arr_wa = {base_q[ADDR_W-1:PAGE_W], base_q[PAGE_W-1:0] + idx_q[PAGE_W-1:0]};
      FPE_SECT: arr_wa = {base_q[ADDR_W-1:SECT_W], idx_q[SECT_W-1:0]};
      default:  arr_wa = idx_q[ADDR_W-1:0];
    endcase
  end

  assign arr_we   = busy && (idx_q < len);
  assign arr_set  = (op_q != FPE_PROG);
  assign buf_slot = idx_q[PAGE_W-1:0];
  assign buf_clr  = busy && (remain_q == '0) && (op_q == FPE_PROG);
endmodule

// File: rtl/fpe_engine.sv
module fpe_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter int T_PP   = 300,
  parameter int T_SE   = 600,
  parameter int T_BE   = 2100,
  parameter int T_W    = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [PAGE_W:0]   fill;
  logic [PAGE_W-1:0] buf_slot;
  logic [7:0]        buf_byte;
  logic              buf_clr;
  logic              arr_we;
  logic              arr_set;
  logic [ADDR_W-1:0] arr_wa;
  logic              push;

  assign s_ready = !busy;
  assign push    = s_valid && s_ready;

  fpe_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .din(s_data), .clr(buf_clr),
    .rd_slot(buf_slot), .rd_byte(buf_byte), .fill(fill)
  );

  fpe_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
    .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_W(T_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(fpe_op_e'(op)), .addr(addr),
    .fill(fill), .busy(busy), .done(done), .arr_we(arr_we), .arr_set(arr_set),
    .arr_wa(arr_wa), .buf_slot(buf_slot), .buf_clr(buf_clr)
  );

  fpe_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .set_ff(arr_set), .wa(arr_wa), .wd(buf_byte),
    .ra(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter int T_PP   = 300,
  parameter int T_SE   = 600,
  parameter int T_BE   = 2100,
  parameter int T_W    = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic       done,
  input logic       s_ready,
  input logic       arr_we
);
  localparam int PB = 1 << PAGE_W;
  localparam int SB = 1 << SECT_W;
  localparam int AB = 1 << ADDR_W;
  localparam int L0 = (T_PP > PB) ? T_PP : PB;
  localparam int L1 = (T_SE > SB) ? T_SE : SB;
  localparam int L2 = (T_BE > AB) ? T_BE : AB;
  localparam int L3 = (T_W > 1) ? T_W : 1;

  int exp_q;
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 0;
      run_q <= 0;
    end else if (!busy && start) begin
      run_q <= 0;
      case (op)
        2'd0:    exp_q <= L0;
        2'd1:    exp_q <= L1;
        2'd2:    exp_q <= L2;
        default: exp_q <= L3;
      endcase
    end else if (busy) begin
      run_q <= run_q + 1;
    end
  end

  a_r7_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == exp_q));
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_ready_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready != busy);
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arr_we);
endmodule

bind fpe_engine fpe_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
  .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_W(T_W)
) u_fpe_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy),
  .done(done), .s_ready(s_ready), .arr_we(arr_we)
);

// File: tb/fpe_engine_bench.sv
module fpe_engine_bench;
  localparam int AW = 11;
  localparam int NB = 1 << AW;
  localparam int LP = 300, LS = 600, LB = 2100, LW = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, s_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0] s_data = '0, rd_data;
  logic s_ready, busy, done;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [NB];

  always #2 clk = ~clk;

  fpe_engine #(.ADDR_W(AW), .PAGE_W(8), .SECT_W(9),
    .T_PP(LP), .T_SE(LS), .T_BE(LB), .T_W(LW)) u_fpe_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data));

  // {op, addr, byte count, seed, expected busy cycles}
  localparam logic [63:0] VEC [10] = '{
    {8'd2, 16'h000, 16'd0,   8'h00, 16'(LB)},  // R6 bulk erase
    {8'd0, 16'h105, 16'd10,  8'hA5, 16'(LP)},  // R4 program
    {8'd0, 16'h1FA, 16'd12,  8'h3C, 16'(LP)},  // R2 column wrap, AND over old data
    {8'd0, 16'h7F0, 16'd300, 8'h5A, 16'(LP)},  // R3 last 256 kept
    {8'd1, 16'h123, 16'd0,   8'h00, 16'(LS)},  // R5 sector 0
    {8'd0, 16'h200, 16'd256, 8'h11, 16'(LP)},  // R4 full page
    {8'd3, 16'h000, 16'd0,   8'h00, 16'(LW)},  // R7 status write
    {8'd1, 16'h6A0, 16'd0,   8'h00, 16'(LS)},  // R5 sector 3
    {8'd0, 16'h233, 16'd0,   8'h00, 16'(LP)},  // R10 empty program
    {8'd0, 16'h2FF, 16'd1,   8'h0F, 16'(LP)}   // R2 last column
  };

  function automatic logic [7:0] dbyte(logic [7:0] seed, int k);
    return seed + 8'(k * 3);
  endfunction

  task automatic chk(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push_bytes(int n, logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = dbyte(seed, k);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic model_apply(int o, int a, int n, logic [7:0] seed);
    if (o == 0) begin
      for (int k = 0; k < n; k++)
        if (n <= 256 || k >= n - 256)
          model[{a[10:8], 8'(a[7:0] + k)}] &= dbyte(seed, k);
    end else if (o == 1) begin
      for (int i = 0; i < 512; i++) model[(a & 'h600) + i] = 8'hFF;
    end else if (o == 2) begin
      for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    end
  endtask

  task automatic scan(string req);
    int bad = 0, bad_a = 0, bad_g = 0, bad_e = 0;
    rd_addr = '0;
    @(negedge clk);
    for (int a = 0; a < NB; a++) begin
      if (rd_data !== model[a] && bad == 0) begin
        bad_a = a; bad_g = int'(rd_data); bad_e = int'(model[a]);
      end
      if (rd_data !== model[a]) bad++;
      rd_addr = AW'(a + 1);
      @(negedge clk);
    end
    if (bad != 0) $display("  mismatch at %0h (%0d bytes)", bad_a, bad);
    chk(bad == 0, req, bad_g, bad_e);
  endtask

  // Issues the start, optionally re-strobes mid-window, returns busy length.
  task automatic run_op(int o, int a, int n, logic [7:0] seed, int exp,
                        bit restrobe, string req);
    int cnt = 0;
    push_bytes(n, seed);
    op = 2'(o); addr = AW'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(s_ready == 1'b0 && busy == 1'b1, "R2 ready low while busy", int'(s_ready), 0);
    while (busy && cnt < 5000) begin
      cnt++;
      if (restrobe && cnt == 10) begin op = 2'd2; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cnt == exp, {"R7 busy length ", req}, cnt, exp);
    chk(done == 1'b1, "R8 done after busy", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    model_apply(o, a, n, seed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, held and after release
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);
    chk(s_ready == 1'b1, "R1 ready after reset", int'(s_ready), 1);

    for (int i = 0; i < 10; i++) begin
      logic [63:0] v = VEC[i];
      run_op(int'(v[63:56]), int'(v[55:40]), int'(v[39:24]), v[23:16],
             int'(v[15:0]), 1'b0, $sformatf("vector %0d", i));
      scan($sformatf("R4 R5 R6 R11 array contents after vector %0d", i));
    end

    // R9: a bulk erase strobe mid-window of a status write is ignored
    run_op(3, 0, 0, 8'h00, LW, 1'b1, "R9 restrobe during status write");
    scan("R9 array unchanged by ignored start");

    // R2 / R10: bytes offered while busy are dropped, so an empty program changes nothing
    op = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0; s_valid = 1'b1; s_data = 8'h00;
    repeat (20) @(negedge clk);
    chk(s_ready == 1'b0, "R2 ready low with valid held", int'(s_ready), 0);
    s_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    run_op(0, 'h300, 0, 8'h00, LP, 1'b0, "R10 program after dropped bytes");
    scan("R2 R10 dropped bytes left no trace");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule